// File: doc/BRIEF.md
# Scan Cycle Watchdog

This block supervises the program scan of a small logic controller. It watches the stream of executed instructions and restarts a timeout counter each time a marker instruction executes. There are three marker instructions: the unconditional block end, the conditional block end, and the scan of the interrupt flag. A correctly running program passes through one of them many times inside the timeout window. A 1K-instruction scan at about 20 us per instruction takes roughly 20 ms, and the window is 200 ms.

Suppose the window elapses with no marker instruction. The block then latches a cycle fault. It lights a fault indicator and removes the drive from the watchdog relay, which opens the relay's interlock contact. It also drops an output-enable gate, which the surrounding logic uses to force every process output to logic 0.

The window length is given in milliseconds and the clock rate in kHz. The terminal count is computed from these two values. The three marker opcodes are also parameters.

Top module: `scan_wdog`

## Requirements
- R1: Right after a synchronous reset (rst_n low at a rising edge), the outputs are: cycle_fault 0, relay_drive 1, out_enable 1.
- R2: An instruction counts as a kick when instr_vld is 1 and opcode equals the unconditional block-end code (default 16'h6500). A kick restarts the timeout window.
- R3: An instruction counts as a kick when instr_vld is 1 and opcode equals the conditional block-end code (default 16'h6501). A kick restarts the timeout window.
- R4: An instruction counts as a kick when instr_vld is 1 and opcode equals the interrupt-flag scan code (default 16'h7000). A kick restarts the timeout window.
- R5: Let LIMIT = WINDOW_MS * CLK_KHZ. cycle_fault rises at the rising edge that completes LIMIT consecutive edges without a kick, counted from the last kick or from reset. It never rises earlier.
- R6: relay_drive is 1 while no fault is latched. It falls at the same edge at which cycle_fault rises.
- R7: out_enable is 1 while no fault is latched. It falls at the same edge at which cycle_fault rises.
- R8: A marker opcode presented while instr_vld is 0 is not a kick. The window keeps running.
- R9: Any opcode other than the three marker codes is not a kick, even when instr_vld is 1.
- R10: Once latched, the fault stays set. Later kicks do not clear it.
- R11: A reset clears a latched fault and restarts the window from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_vld | input | 1 | High for one cycle per executed instruction |
| opcode | input | OPC_W | Opcode of the executed instruction |
| cycle_fault | output | 1 | Latched cycle-fault indicator |
| relay_drive | output | 1 | Watchdog relay coil drive; low opens the interlock |
| out_enable | output | 1 | Process-output gate; low forces all outputs to 0 |

## Verification
The assertions are checked on every cycle. They cover the following:
- the exact trip edge against an idle counter kept at the ports;
- that the fault never appears earlier;
- that the fault is sticky;
- that the relay and gate track the fault;
- that a kick always keeps the next cycle fault-free.

Some behaviour only the bench scenarios can show. The first is that each marker opcode in turn rescues the window at its very last edge. The second is that strobe-less markers and foreign opcodes leave the trip time unchanged. The third is that a reset recovers the block after a trip.

// File: rtl/scan_wdog_pkg.sv
// Shared definitions for the scan cycle watchdog.
// Assumes: three kick sources, in the order block end, conditional block end,
// interrupt-flag scan.
package scan_wdog_pkg;
    localparam int unsigned KICK_SRCS = 3;

    // Watchdog health state
    typedef enum logic {
        WD_RUN     = 1'b0,
        WD_TRIPPED = 1'b1
    } wd_state_e;
endpackage

// File: rtl/scan_wdog_kick_dec.sv
// Kick decoder: flags a cycle in which a marker instruction executes.
// Assumes: opcode is meaningful only while instr_vld is high.
module scan_wdog_kick_dec
    import scan_wdog_pkg::*;
#(
    parameter int unsigned    OPC_W  = 16,
    parameter logic [OPC_W-1:0] OP_BE  = 16'h6500,
    parameter logic [OPC_W-1:0] OP_BEC = 16'h6501,
    parameter logic [OPC_W-1:0] OP_IRQ = 16'h7000
) (
    input  logic             instr_vld,
    input  logic [OPC_W-1:0] opcode,
    output logic             kick
);
    localparam logic [KICK_SRCS*OPC_W-1:0] CODES = {OP_IRQ, OP_BEC, OP_BE};

    logic [KICK_SRCS-1:0] hit;

    // One comparator per marker opcode
    for (genvar g = 0; g < KICK_SRCS; g++) begin : g_cmp
        assign hit[g] = instr_vld && (opcode == CODES[g*OPC_W +: OPC_W]);
    end

    assign kick = |hit;
endmodule

// File: rtl/scan_wdog_timer.sv
// Timeout counter: counts edges since the last kick and signals expiry on
// the edge that would complete LIMIT idle edges.
// Assumes: LIMIT >= 2.
module scan_wdog_timer #(
    parameter int unsigned LIMIT = 25000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expire
);
    localparam int unsigned CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Idle edge counter, cleared by a kick, saturating at LAST
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = !kick && (cnt_q == LAST);
endmodule

// File: rtl/scan_wdog_fault.sv
// Fault latch: holds the tripped state and drives relay and output gate.
// Assumes: only reset leaves the tripped state.
module scan_wdog_fault
    import scan_wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic cycle_fault,
    output logic relay_drive,
    output logic out_enable
);
    wd_state_e state_q;
    logic      relay_q;
    logic      gate_q;

    // Health state: trips on expiry, sticky until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
        end else if (expire) begin
            state_q <= WD_TRIPPED;
        end
    end

    // Relay coil drive: energised while healthy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relay_q <= 1'b1;
        end else if (expire) begin
            relay_q <= 1'b0;
        end
    end

    // Process-output gate: open while healthy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
        end else if (expire) begin
            gate_q <= 1'b0;
        end
    end

    assign cycle_fault = (state_q == WD_TRIPPED);
    assign relay_drive = relay_q;
    assign out_enable  = gate_q;
endmodule

// File: rtl/scan_wdog.sv
// Scan cycle watchdog top: decodes marker instructions, times the window
// and latches a cycle fault.
// Assumes: CLK_KHZ * WINDOW_MS >= 2 and fits in 32 bits.
module scan_wdog #(
    parameter int unsigned      CLK_KHZ   = 125000,
    parameter int unsigned      WINDOW_MS = 200,
    parameter int unsigned      OPC_W     = 16,
    parameter logic [OPC_W-1:0] OP_BE     = 16'h6500,
    parameter logic [OPC_W-1:0] OP_BEC    = 16'h6501,
    parameter logic [OPC_W-1:0] OP_IRQ    = 16'h7000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_vld,
    input  logic [OPC_W-1:0] opcode,
    output logic             cycle_fault,
    output logic             relay_drive,
    output logic             out_enable
);
    localparam int unsigned LIMIT = WINDOW_MS * CLK_KHZ;

    logic kick;
    logic expire;

    scan_wdog_kick_dec #(
        .OPC_W (OPC_W),
        .OP_BE (OP_BE),
        .OP_BEC(OP_BEC),
        .OP_IRQ(OP_IRQ)
    ) dec_i (
        .instr_vld(instr_vld),
        .opcode   (opcode),
        .kick     (kick)
    );

    scan_wdog_timer #(
        .LIMIT(LIMIT)
    ) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (kick),
        .expire(expire)
    );

    scan_wdog_fault flt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .cycle_fault(cycle_fault),
        .relay_drive(relay_drive),
        .out_enable (out_enable)
    );
endmodule

// File: rtl/scan_wdog_chk.sv
// Checker for scan_wdog: keeps its own idle count from the ports and
// checks trip timing and output consistency.
module scan_wdog_chk #(
    parameter int unsigned      CLK_KHZ   = 125000,
    parameter int unsigned      WINDOW_MS = 200,
    parameter int unsigned      OPC_W     = 16,
    parameter logic [OPC_W-1:0] OP_BE     = 16'h6500,
    parameter logic [OPC_W-1:0] OP_BEC    = 16'h6501,
    parameter logic [OPC_W-1:0] OP_IRQ    = 16'h7000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_vld,
    input logic [OPC_W-1:0] opcode,
    input logic             cycle_fault,
    input logic             relay_drive,
    input logic             out_enable
);
    localparam int unsigned LIMIT = WINDOW_MS * CLK_KHZ;

    logic        port_kick;
    logic [31:0] idle_q;

    assign port_kick = instr_vld &&
                       ((opcode == OP_BE) || (opcode == OP_BEC) || (opcode == OP_IRQ));

    // Port-side idle counter, saturating one below the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (port_kick) begin
            idle_q <= '0;
        end else if (idle_q != LIMIT - 1) begin
            idle_q <= idle_q + 32'd1;
        end
    end

    a_r5_trip_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_fault && !port_kick && idle_q == LIMIT - 1) |=> cycle_fault);

    a_r5_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_fault && (port_kick || idle_q != LIMIT - 1)) |=> !cycle_fault);

    // R3 and R4 share this property with R2
    a_r2_kick_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_fault && port_kick) |=> !cycle_fault);

    a_r6_relay_tracks_fault: assert property (@(posedge clk) disable iff (!rst_n)
        relay_drive == !cycle_fault);

    a_r7_gate_tracks_fault: assert property (@(posedge clk) disable iff (!rst_n)
        out_enable == !cycle_fault);

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_fault |=> cycle_fault);

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!cycle_fault && relay_drive && out_enable));
endmodule

bind scan_wdog scan_wdog_chk #(
    .CLK_KHZ  (CLK_KHZ),
    .WINDOW_MS(WINDOW_MS),
    .OPC_W    (OPC_W),
    .OP_BE    (OP_BE),
    .OP_BEC   (OP_BEC),
    .OP_IRQ   (OP_IRQ)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_vld  (instr_vld),
    .opcode     (opcode),
    .cycle_fault(cycle_fault),
    .relay_drive(relay_drive),
    .out_enable (out_enable)
);

// File: tb/scan_wdog_tb_top.sv
// Bench for scan_wdog: behavioural reference model compared every cycle,
// plus scenario checks at hand-computed edges. Window scaled to 40 edges.
module scan_wdog_tb_top;
    localparam int unsigned CLK_KHZ   = 1;
    localparam int unsigned WINDOW_MS = 40;
    localparam int          LIMIT     = 40;
    localparam logic [15:0] C_BE  = 16'h6500;
    localparam logic [15:0] C_BEC = 16'h6501;
    localparam logic [15:0] C_IRQ = 16'h7000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [15:0] opcode = '0;
    logic        cycle_fault, relay_drive, out_enable;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    scan_wdog #(
        .CLK_KHZ(CLK_KHZ), .WINDOW_MS(WINDOW_MS), .OPC_W(16),
        .OP_BE(C_BE), .OP_BEC(C_BEC), .OP_IRQ(C_IRQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .opcode(opcode),
        .cycle_fault(cycle_fault), .relay_drive(relay_drive), .out_enable(out_enable)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Reference model
    logic [15:0] kick_codes [$] = '{C_BE, C_BEC, C_IRQ};
    int   m_idle  = 0;
    logic m_fault = 1'b0;
    bit   started = 0;

    function automatic bit is_kick(logic v, logic [15:0] op);
        if (!v) return 0;
        foreach (kick_codes[i]) if (kick_codes[i] == op) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_idle  = 0;
            m_fault = 1'b0;
        end else if (!m_fault) begin
            if (is_kick(instr_vld, opcode)) m_idle = 0;
            else begin
                m_idle++;
                if (m_idle == LIMIT) m_fault = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check("R5", "model cycle_fault", cycle_fault, m_fault);
            check("R6", "model relay_drive", relay_drive, !m_fault);
            check("R7", "model out_enable", out_enable, !m_fault);
        end
    end

    // Drive for n cycles, starting at the current negedge
    task automatic hold(input logic v, input logic [15:0] op, input int n);
        instr_vld = v;
        opcode    = op;
        for (int i = 0; i < n; i++) @(negedge clk);
        instr_vld = 1'b0;
        opcode    = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hold(1'b0, '0, 3);
        rst_n = 1'b1;
    endtask

    task automatic expect_state(input string req, input logic f);
        check(req, "cycle_fault", cycle_fault, f);
        check(req, "relay_drive", relay_drive, !f);
        check(req, "out_enable", out_enable, !f);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect_state("R1", 1'b0);

        // Window runs to its last idle edge, then each marker rescues it
        hold(1'b0, '0, LIMIT - 1);
        expect_state("R5", 1'b0);
        hold(1'b1, C_BE, 1);
        hold(1'b0, '0, LIMIT - 1);
        expect_state("R2", 1'b0);
        hold(1'b1, C_BEC, 1);
        hold(1'b0, '0, LIMIT - 1);
        expect_state("R3", 1'b0);
        hold(1'b1, C_IRQ, 1);

        // Marker without strobe does not kick
        hold(1'b0, C_BE, LIMIT - 1);
        expect_state("R8", 1'b0);
        hold(1'b0, C_IRQ, 1);
        expect_state("R8", 1'b1);
        check("R4", "fault after IRQ kick window", cycle_fault, 1'b1);

        // Sticky fault
        hold(1'b1, C_BE, 1);
        hold(1'b1, C_BEC, 1);
        hold(1'b1, C_IRQ, 3);
        expect_state("R10", 1'b1);

        // Reset recovers
        do_reset();
        expect_state("R11", 1'b0);

        // Foreign opcodes with strobe do not kick
        hold(1'b1, 16'h6502, LIMIT - 1);
        expect_state("R9", 1'b0);
        hold(1'b1, 16'h0000, 1);
        expect_state("R9", 1'b1);

        // Trip edge exact after reset with a kick midway
        do_reset();
        hold(1'b0, '0, 10);
        hold(1'b1, C_IRQ, 1);
        hold(1'b0, '0, LIMIT - 1);
        expect_state("R5", 1'b0);
        hold(1'b0, '0, 1);
        expect_state("R5", 1'b1);
        check("R6", "relay after trip", relay_drive, 1'b0);
        check("R7", "gate after trip", out_enable, 1'b0);

        hold(1'b0, '0, 2);
        finish_run();
    end
endmodule